// File: doc/BRIEF.md
# MAC Address Learning Table

This block is the forwarding database of a small learning Ethernet switch. For each received frame it gets the source MAC, the destination MAC and the ingress port. It looks up the destination to build a one-bit-per-port forwarding mask. In the same step it learns or refreshes the source address. The first time an address is learned, it raises a notification so that the address can be passed on to peer switching devices.

Entries are held on chip in a hashed, set-associative table. Each bucket has a fixed number of ways. Every entry carries:
- a target port,
- a refreshed (age) bit,
- a static flag,
- a flag that forces a copy of the frame to the CPU.

A management interface lets the CPU write entries (insert or modify) and delete them. It takes priority over learning. A periodic aging tick removes dynamic entries that nothing has refreshed.

Top module: `mac_learn_table`

## Requirements
- R1: A frame whose unicast source MAC (bit 40 clear) is absent from the table is stored with its ingress port as a dynamic entry. A later unicast frame to that MAC gets a mask with only that port's bit set.
- R2: `learn_new_o` pulses for one cycle, together with `fwd_valid_o`, carrying the MAC and port, only when an address is learned for the first time. A refresh, a move or a management write raises no pulse.
- R3: A unicast destination that misses gets the mask `flood_en_i` with the ingress port bit cleared.
- R4: A destination with bit 40 set (multicast or broadcast) goes to the CPU port bit alone when `cpu_present_i` is 1, and is flooded as in R3 otherwise. A source with bit 40 set is never learned.
- R5: On a unicast destination hit, the mask holds the entry's port bit, except when that port equals the ingress port. If the entry's intervene flag is set, the CPU port bit is added as well.
- R6: A source hit on a dynamic entry sets its port to the ingress port. Learning never changes a static entry.
- R7: When `mg_valid_i` is high, op 2'b00 inserts the MAC or modifies it (port, static and intervene flags) and op 2'b01 deletes it. Ops 2'b10 and 2'b11 change nothing.
- R8: Each `age_tick_i` clears the refreshed bit of every dynamic entry that has it, and removes every dynamic entry that lacks it. Learning a source, refreshing it and management writes all set the bit. Static entries never age out.
- R9: The bucket index is a 4-bit hash (with BUCKETS=16): bit j is the XOR of all MAC bits whose position modulo 4 equals j. Each bucket holds WAYS entries. A source miss in a full bucket is dropped, with no notification, and `learn_drop_cnt_o` increments by one.
- R10: If `mg_valid_i` is high while a frame is pending, the management operation is applied first. That frame's learning and forwarding move one cycle later, `frm_ready_o` is low in that cycle, and the result sees the table after the management write.
- R11: A frame is taken on a clock edge where `frm_valid_i` and `frm_ready_o` are both high. Its result appears one clock later unless stalled. After reset the table is empty, `frm_ready_o` is 1, and the pulse outputs and the drop count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid_i | input | 1 | Frame header present |
| frm_ready_o | output | 1 | Frame header can be taken |
| frm_sa_i | input | 48 | Source MAC |
| frm_da_i | input | 48 | Destination MAC |
| frm_port_i | input | 3 | Ingress port |
| fwd_valid_o | output | 1 | Forwarding result valid (one cycle) |
| fwd_mask_o | output | 8 | Egress port mask |
| learn_new_o | output | 1 | New address learned (one cycle) |
| learn_mac_o | output | 48 | Newly learned MAC |
| learn_port_o | output | 3 | Port of newly learned MAC |
| learn_drop_cnt_o | output | 16 | Count of learn attempts lost to full buckets |
| cpu_present_i | input | 1 | A CPU handles multicast decisions |
| flood_en_i | input | 8 | Ports that receive unknown and flooded traffic |
| age_tick_i | input | 1 | Aging sweep strobe |
| mg_valid_i | input | 1 | Management operation valid |
| mg_op_i | input | 2 | 00 write, 01 delete, others no-op |
| mg_mac_i | input | 48 | Management MAC |
| mg_port_i | input | 3 | Management target port |
| mg_static_i | input | 1 | Management static flag |
| mg_intv_i | input | 1 | Management intervene flag |

## Verification
The bench fills one bucket beyond its ways. A design that overwrote a live entry, or raised a notification for a dropped learn, would show up in later lookups and in the drop count. It sends frames from a static address on new ports, and it lands a management write on a frame that is already waiting. A design that let learning beat the CPU, or that forwarded on the table as it stood before the write, would misroute the frame or announce the address. Two aging ticks with and without a refresh between them separate a correct design from one that evicts after one tick or never. Back-to-back hits on the ingress port catch missing filtering. Intervene and multicast cases catch a CPU bit that is lost or sent where it does not belong.

// File: rtl/mlt_pkg.sv
`timescale 1ns/1ps
package mlt_pkg;
  localparam int MAC_W     = 48;
  localparam int MCAST_BIT = 40;
  typedef logic [MAC_W-1:0] mac_t;
  typedef enum logic [1:0] {
    MG_WRITE  = 2'b00,
    MG_DELETE = 2'b01,
    MG_RSV2   = 2'b10,
    MG_RSV3   = 2'b11
  } mg_op_e;
endpackage

// File: rtl/mlt_hash.sv
`timescale 1ns/1ps
module mlt_hash
  import mlt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  mac_t             mac_i,
  output logic [IDX_W-1:0] idx_o
);
  // fold the address: bit j collects every MAC bit at position j modulo IDX_W
  always_comb begin
    idx_o = '0;
    for (int b = 0; b < MAC_W; b++) begin
      idx_o[b % IDX_W] = idx_o[b % IDX_W] ^ mac_i[b];
    end
  end
endmodule

// File: rtl/mlt_probe.sv
`timescale 1ns/1ps
module mlt_probe
  import mlt_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  mac_t                        key_i,
  input  logic [WAYS-1:0]             vld_i,
  input  logic [WAYS-1:0][MAC_W-1:0]  mac_i,
  output logic [WAYS-1:0]             match_o,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            hit_way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = vld_i[w] && (mac_i[w] == key_i);
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_o[w]) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/mlt_way_store.sv
`timescale 1ns/1ps
module mlt_way_store
  import mlt_pkg::*;
#(
  parameter int BUCKETS = 16,
  parameter int IDX_W   = 4,
  parameter int PIDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic              a_vld_o,
  output mac_t              a_mac_o,
  output logic              a_stat_o,
  output logic              a_intv_o,
  output logic              b_vld_o,
  output mac_t              b_mac_o,
  output logic [PIDX_W-1:0] b_port_o,
  output logic              b_intv_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_vld_i,
  input  mac_t              wr_mac_i,
  input  logic [PIDX_W-1:0] wr_port_i,
  input  logic              wr_age_i,
  input  logic              wr_stat_i,
  input  logic              wr_intv_i,
  input  logic              wr_mgmt_i,
  input  logic              age_tick_i
);
  logic [BUCKETS-1:0] vld_q, vld_d;
  logic [BUCKETS-1:0] age_q, age_d;
  logic [BUCKETS-1:0] stat_q, stat_d;
  logic [BUCKETS-1:0] intv_q, intv_d;
  mac_t               mac_q  [BUCKETS];
  logic [PIDX_W-1:0]  port_q [BUCKETS];
  logic               data_en;

  always_comb begin
    vld_d  = vld_q;
    age_d  = age_q;
    stat_d = stat_q;
    intv_d = intv_q;
    if (age_tick_i) begin
      for (int i = 0; i < BUCKETS; i++) begin
        if (vld_q[i] && !stat_q[i]) begin
          if (age_q[i]) age_d[i] = 1'b0;
          else          vld_d[i] = 1'b0;
        end
      end
    end
    if (we_i) begin
      vld_d[wr_idx_i]  = wr_vld_i;
      age_d[wr_idx_i]  = wr_age_i;
      stat_d[wr_idx_i] = wr_stat_i;
      intv_d[wr_idx_i] = wr_intv_i;
    end
  end

  assign data_en = we_i && wr_vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      age_q  <= '0;
      stat_q <= '0;
      intv_q <= '0;
    end else begin
      vld_q  <= vld_d;
      age_q  <= age_d;
      stat_q <= stat_d;
      intv_q <= intv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      mac_q[wr_idx_i]  <= wr_mac_i;
      port_q[wr_idx_i] <= wr_port_i;
    end
  end

  assign a_vld_o  = vld_q[rd_a_idx_i];
  assign a_mac_o  = mac_q[rd_a_idx_i];
  assign a_stat_o = stat_q[rd_a_idx_i];
  assign a_intv_o = intv_q[rd_a_idx_i];
  assign b_vld_o  = vld_q[rd_b_idx_i];
  assign b_mac_o  = mac_q[rd_b_idx_i];
  assign b_port_o = port_q[rd_b_idx_i];
  assign b_intv_o = intv_q[rd_b_idx_i];

  for (genvar g = 0; g < BUCKETS; g++) begin : g_chk
    // R6: only a management write may touch a static entry
    assert_static_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[g] && stat_q[g] && !(we_i && wr_mgmt_i && wr_idx_i == IDX_W'(g)))
      |=> (vld_q[g] && stat_q[g] && $stable(port_q[g]) && $stable(mac_q[g])));
    // R8: an unrefreshed dynamic entry is gone after a sweep
    assert_age_evict_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (age_tick_i && vld_q[g] && !stat_q[g] && !age_q[g] && !(we_i && wr_idx_i == IDX_W'(g)))
      |=> !vld_q[g]);
    // R8: a refreshed dynamic entry survives a sweep but loses its mark
    assert_age_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (age_tick_i && vld_q[g] && !stat_q[g] && age_q[g] && !(we_i && wr_idx_i == IDX_W'(g)))
      |=> (vld_q[g] && !age_q[g]));
  end
endmodule

// File: rtl/mac_learn_table.sv
`timescale 1ns/1ps
module mac_learn_table
  import mlt_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int CPU_PORT  = 0,
  parameter int BUCKETS   = 16,
  parameter int WAYS      = 4,
  parameter int CNT_W     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frm_valid_i,
  output logic                          frm_ready_o,
  input  logic [47:0]                   frm_sa_i,
  input  logic [47:0]                   frm_da_i,
  input  logic [$clog2(NUM_PORTS)-1:0]  frm_port_i,
  output logic                          fwd_valid_o,
  output logic [NUM_PORTS-1:0]          fwd_mask_o,
  output logic                          learn_new_o,
  output logic [47:0]                   learn_mac_o,
  output logic [$clog2(NUM_PORTS)-1:0]  learn_port_o,
  output logic [CNT_W-1:0]              learn_drop_cnt_o,
  input  logic                          cpu_present_i,
  input  logic [NUM_PORTS-1:0]          flood_en_i,
  input  logic                          age_tick_i,
  input  logic                          mg_valid_i,
  input  logic [1:0]                    mg_op_i,
  input  logic [47:0]                   mg_mac_i,
  input  logic [$clog2(NUM_PORTS)-1:0]  mg_port_i,
  input  logic                          mg_static_i,
  input  logic                          mg_intv_i
);
  localparam int PIDX_W = $clog2(NUM_PORTS);
  localparam int IDX_W  = $clog2(BUCKETS);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [NUM_PORTS-1:0] CPU_BIT = NUM_PORTS'(1) << CPU_PORT;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // frame stage
  logic              s1_vld_q, s1_vld_d;
  mac_t              s1_sa_q, s1_da_q;
  logic [PIDX_W-1:0] s1_port_q;
  logic              s1_fire, accept;

  assign s1_fire     = s1_vld_q && !mg_valid_i;
  assign frm_ready_o = !s1_vld_q || s1_fire;
  assign accept      = frm_valid_i && frm_ready_o;

  always_comb begin
    s1_vld_d = s1_vld_q;
    if (accept)       s1_vld_d = 1'b1;
    else if (s1_fire) s1_vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) s1_vld_q <= 1'b0;
    else         s1_vld_q <= s1_vld_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_sa_q   <= frm_sa_i;
      s1_da_q   <= frm_da_i;
      s1_port_q <= frm_port_i;
    end
  end

  // lookup keys: port A serves management or source learning, port B the destination
  mac_t             key_a;
  logic [IDX_W-1:0] idx_a, idx_b;
  assign key_a = mg_valid_i ? mg_mac_i : s1_sa_q;

  mlt_hash #(.IDX_W(IDX_W)) u_hash_a (.mac_i(key_a),   .idx_o(idx_a));
  mlt_hash #(.IDX_W(IDX_W)) u_hash_b (.mac_i(s1_da_q), .idx_o(idx_b));

  logic [WAYS-1:0]              a_vld, a_stat, a_intv, b_vld, b_intv, way_we;
  logic [WAYS-1:0][MAC_W-1:0]   a_mac, b_mac;
  logic [WAYS-1:0][PIDX_W-1:0]  b_port;

  logic              wr_en, wr_vld, wr_stat, wr_intv;
  logic [WAY_W-1:0]  wr_way;
  logic [PIDX_W-1:0] wr_port;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_we[w] = wr_en && (wr_way == WAY_W'(w));
    mlt_way_store #(
      .BUCKETS(BUCKETS), .IDX_W(IDX_W), .PIDX_W(PIDX_W)
    ) u_store (
      .clk        (clk),
      .rst_n      (rst_ni),
      .rd_a_idx_i (idx_a),
      .rd_b_idx_i (idx_b),
      .a_vld_o    (a_vld[w]),
      .a_mac_o    (a_mac[w]),
      .a_stat_o   (a_stat[w]),
      .a_intv_o   (a_intv[w]),
      .b_vld_o    (b_vld[w]),
      .b_mac_o    (b_mac[w]),
      .b_port_o   (b_port[w]),
      .b_intv_o   (b_intv[w]),
      .we_i       (way_we[w]),
      .wr_idx_i   (idx_a),
      .wr_vld_i   (wr_vld),
      .wr_mac_i   (key_a),
      .wr_port_i  (wr_port),
      .wr_age_i   (wr_vld),
      .wr_stat_i  (wr_stat),
      .wr_intv_i  (wr_intv),
      .wr_mgmt_i  (mg_valid_i),
      .age_tick_i (age_tick_i)
    );
  end

  logic [WAYS-1:0]  a_match, b_match;
  logic             a_hit, b_hit, a_free;
  logic [WAY_W-1:0] a_hit_way, b_hit_way, a_free_way;

  mlt_probe #(.WAYS(WAYS), .WAY_W(WAY_W)) u_probe_a (
    .key_i(key_a), .vld_i(a_vld), .mac_i(a_mac),
    .match_o(a_match), .hit_o(a_hit), .hit_way_o(a_hit_way));
  mlt_probe #(.WAYS(WAYS), .WAY_W(WAY_W)) u_probe_b (
    .key_i(s1_da_q), .vld_i(b_vld), .mac_i(b_mac),
    .match_o(b_match), .hit_o(b_hit), .hit_way_o(b_hit_way));

  // lowest empty way of the source bucket
  always_comb begin
    a_free     = 1'b0;
    a_free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!a_vld[w]) begin
        a_free     = 1'b1;
        a_free_way = WAY_W'(w);
      end
    end
  end

  // write decision: management first, then learning
  logic new_d, drop_inc;
  always_comb begin
    wr_en    = 1'b0;
    wr_way   = '0;
    wr_vld   = 1'b1;
    wr_port  = s1_port_q;
    wr_stat  = 1'b0;
    wr_intv  = 1'b0;
    new_d    = 1'b0;
    drop_inc = 1'b0;
    if (mg_valid_i) begin
      wr_port = mg_port_i;
      wr_stat = mg_static_i;
      wr_intv = mg_intv_i;
      case (mg_op_i)
        MG_WRITE: begin
          if (a_hit) begin
            wr_en  = 1'b1;
            wr_way = a_hit_way;
          end else if (a_free) begin
            wr_en  = 1'b1;
            wr_way = a_free_way;
          end
        end
        MG_DELETE: begin
          if (a_hit) begin
            wr_en  = 1'b1;
            wr_way = a_hit_way;
            wr_vld = 1'b0;
          end
        end
        default: ;
      endcase
    end else if (s1_fire && !s1_sa_q[MCAST_BIT]) begin
      if (a_hit) begin
        if (!a_stat[a_hit_way]) begin
          wr_en   = 1'b1;
          wr_way  = a_hit_way;
          wr_intv = a_intv[a_hit_way];
        end
      end else if (a_free) begin
        wr_en  = 1'b1;
        wr_way = a_free_way;
        new_d  = 1'b1;
      end else begin
        drop_inc = 1'b1;
      end
    end
  end

  // forwarding decision
  logic [NUM_PORTS-1:0] ing_bit, flood_mask, hit_bit, mask_d;
  logic [PIDX_W-1:0]    dst_port;
  assign ing_bit    = NUM_PORTS'(1) << s1_port_q;
  assign flood_mask = flood_en_i & ~ing_bit;
  assign dst_port   = b_port[b_hit_way];
  assign hit_bit    = (dst_port == s1_port_q) ? '0 : (NUM_PORTS'(1) << dst_port);

  always_comb begin
    if (s1_da_q[MCAST_BIT]) begin
      mask_d = cpu_present_i ? CPU_BIT : flood_mask;
    end else if (b_hit) begin
      mask_d = hit_bit | (b_intv[b_hit_way] ? CPU_BIT : '0);
    end else begin
      mask_d = flood_mask;
    end
  end

  // output registers
  logic [CNT_W-1:0] drop_cnt_d;
  assign drop_cnt_d = learn_drop_cnt_o + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o      <= 1'b0;
      learn_new_o      <= 1'b0;
      learn_drop_cnt_o <= '0;
    end else begin
      fwd_valid_o <= s1_fire;
      learn_new_o <= new_d;
      if (drop_inc) learn_drop_cnt_o <= drop_cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_fire) fwd_mask_o <= mask_d;
    if (new_d) begin
      learn_mac_o  <= s1_sa_q;
      learn_port_o <= s1_port_q;
    end
  end

  // R10: a management cycle never yields a forwarding result one cycle later
  assert_mgmt_first_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    mg_valid_i |=> !fwd_valid_o);
  // R2: a notification always accompanies the frame's forwarding result
  assert_notify_with_fwd_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    learn_new_o |-> fwd_valid_o);
  // R9: the drop counter moves by at most one per cycle
  assert_drop_step_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> (learn_drop_cnt_o == $past(learn_drop_cnt_o)) ||
             (learn_drop_cnt_o == $past(learn_drop_cnt_o) + CNT_W'(1)));
  // R1: an address is held in at most one way
  assert_unique_src_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones(a_match) <= 1);
  assert_unique_dst_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones(b_match) <= 1);
endmodule

// File: tb/mac_learn_table_tb.sv
`timescale 1ns/1ps
module mac_learn_table_tb;
  localparam int NB = 16;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frm_valid;
  logic        frm_ready;
  logic [47:0] frm_sa, frm_da;
  logic [2:0]  frm_port;
  logic        fwd_valid;
  logic [7:0]  fwd_mask;
  logic        learn_new;
  logic [47:0] learn_mac;
  logic [2:0]  learn_port;
  logic [15:0] drop_cnt;
  logic        cpu_present;
  logic [7:0]  flood_en;
  logic        age_tick;
  logic        mg_valid;
  logic [1:0]  mg_op;
  logic [47:0] mg_mac;
  logic [2:0]  mg_port;
  logic        mg_static, mg_intv;

  always #2.5 clk = ~clk;

  mac_learn_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .frm_valid_i(frm_valid), .frm_ready_o(frm_ready),
    .frm_sa_i(frm_sa), .frm_da_i(frm_da), .frm_port_i(frm_port),
    .fwd_valid_o(fwd_valid), .fwd_mask_o(fwd_mask),
    .learn_new_o(learn_new), .learn_mac_o(learn_mac), .learn_port_o(learn_port),
    .learn_drop_cnt_o(drop_cnt),
    .cpu_present_i(cpu_present), .flood_en_i(flood_en), .age_tick_i(age_tick),
    .mg_valid_i(mg_valid), .mg_op_i(mg_op), .mg_mac_i(mg_mac), .mg_port_i(mg_port),
    .mg_static_i(mg_static), .mg_intv_i(mg_intv));

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] exp_drop = '0;

  // reference table
  logic        m_vld  [NB][NW];
  logic [47:0] m_mac  [NB][NW];
  logic [2:0]  m_port [NB][NW];
  logic        m_age  [NB][NW];
  logic        m_stat [NB][NW];
  logic        m_intv [NB][NW];

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] f_hash(input logic [47:0] m);
    logic [3:0] h = '0;
    for (int b = 0; b < 48; b++) h[b % 4] = h[b % 4] ^ m[b];
    return h;
  endfunction

  function automatic logic [47:0] mk_mac(input int unsigned bkt);
    logic [47:0] m;
    m = 48'({$urandom(), $urandom()});
    m[40]  = 1'b0;
    m[3:0] = 4'h0;
    m[3:0] = f_hash(m) ^ 4'(bkt);
    return m;
  endfunction

  function automatic int m_find(input logic [47:0] mac);
    int b = int'(f_hash(mac));
    for (int w = 0; w < NW; w++) if (m_vld[b][w] && m_mac[b][w] == mac) return w;
    return -1;
  endfunction

  function automatic int m_free(input logic [47:0] mac);
    int b = int'(f_hash(mac));
    for (int w = 0; w < NW; w++) if (!m_vld[b][w]) return w;
    return -1;
  endfunction

  function automatic logic [7:0] m_fwd(input logic [47:0] da, input logic [2:0] p);
    logic [7:0] ing = 8'(1) << p;
    logic [7:0] r;
    int b = int'(f_hash(da));
    int w;
    if (da[40]) return cpu_present ? 8'h01 : (flood_en & ~ing);
    w = m_find(da);
    if (w < 0) return flood_en & ~ing;
    r = (m_port[b][w] == p) ? 8'h00 : (8'(1) << m_port[b][w]);
    if (m_intv[b][w]) r = r | 8'h01;
    return r;
  endfunction

  function automatic void m_learn(input logic [47:0] sa, input logic [2:0] p,
                                  output logic nw, output logic dr);
    int b = int'(f_hash(sa));
    int w;
    nw = 1'b0;
    dr = 1'b0;
    if (sa[40]) return;
    w = m_find(sa);
    if (w >= 0) begin
      if (!m_stat[b][w]) begin
        m_port[b][w] = p;
        m_age[b][w]  = 1'b1;
      end
      return;
    end
    w = m_free(sa);
    if (w < 0) begin
      dr = 1'b1;
      return;
    end
    m_vld[b][w] = 1'b1; m_mac[b][w] = sa; m_port[b][w] = p;
    m_age[b][w] = 1'b1; m_stat[b][w] = 1'b0; m_intv[b][w] = 1'b0;
    nw = 1'b1;
  endfunction

  function automatic void m_mgmt(input logic [1:0] op, input logic [47:0] mac,
                                 input logic [2:0] p, input logic st, input logic iv);
    int b = int'(f_hash(mac));
    int w = m_find(mac);
    if (op == 2'b00) begin
      if (w < 0) w = m_free(mac);
      if (w >= 0) begin
        m_vld[b][w] = 1'b1; m_mac[b][w] = mac; m_port[b][w] = p;
        m_age[b][w] = 1'b1; m_stat[b][w] = st; m_intv[b][w] = iv;
      end
    end else if (op == 2'b01) begin
      if (w >= 0) m_vld[b][w] = 1'b0;
    end
  endfunction

  function automatic void m_sweep();
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < NW; w++)
        if (m_vld[b][w] && !m_stat[b][w]) begin
          if (m_age[b][w]) m_age[b][w] = 1'b0;
          else             m_vld[b][w] = 1'b0;
        end
  endfunction

  task automatic check_result(input string req, input logic [7:0] em,
                              input logic nw, input logic [47:0] sa, input logic [2:0] p);
    chk(req, "fwd_valid", fwd_valid, 1);
    chk(req, "fwd_mask", fwd_mask, em);
    chk(req, "learn_new", learn_new, nw);
    if (nw) begin
      chk(req, "learn_mac", learn_mac, sa);
      chk(req, "learn_port", learn_port, p);
    end
    chk(req, "drop_cnt", drop_cnt, exp_drop);
  endtask

  task automatic send_frame(input logic [47:0] sa, input logic [47:0] da,
                            input logic [2:0] p, input string req);
    logic [7:0] em;
    logic nw, dr;
    em = m_fwd(da, p);
    m_learn(sa, p, nw, dr);
    if (dr) exp_drop++;
    @(negedge clk);
    frm_valid = 1'b1; frm_sa = sa; frm_da = da; frm_port = p;
    @(negedge clk);
    frm_valid = 1'b0;
    @(negedge clk);
    check_result(req, em, nw, sa, p);
  endtask

  task automatic send_mgmt(input logic [1:0] op, input logic [47:0] mac,
                           input logic [2:0] p, input logic st, input logic iv);
    m_mgmt(op, mac, p, st, iv);
    @(negedge clk);
    mg_valid = 1'b1; mg_op = op; mg_mac = mac; mg_port = p; mg_static = st; mg_intv = iv;
    @(negedge clk);
    mg_valid = 1'b0;
  endtask

  task automatic send_tick();
    m_sweep();
    @(negedge clk);
    age_tick = 1'b1;
    @(negedge clk);
    age_tick = 1'b0;
  endtask

  // a management write lands while a frame waits in the lookup stage
  task automatic stall_case(input logic [47:0] sa, input logic [47:0] da, input logic [2:0] p);
    logic [7:0] em;
    logic nw, dr;
    @(negedge clk);
    frm_valid = 1'b1; frm_sa = sa; frm_da = da; frm_port = p;
    @(negedge clk);
    frm_valid = 1'b0;
    mg_valid = 1'b1; mg_op = 2'b00; mg_mac = sa; mg_port = 3'd7; mg_static = 1'b1; mg_intv = 1'b0;
    #0.1;
    chk("R10", "frm_ready during mgmt", frm_ready, 0);
    m_mgmt(2'b00, sa, 3'd7, 1'b1, 1'b0);
    em = m_fwd(da, p);
    m_learn(sa, p, nw, dr);
    if (dr) exp_drop++;
    @(negedge clk);
    mg_valid = 1'b0;
    chk("R10", "fwd_valid held back", fwd_valid, 0);
    @(negedge clk);
    check_result("R10", em, nw, sa, p);
  endtask

  initial begin
    #(150000 * 5.0);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] a, b, c, d, e, mc;
    logic [47:0] full [5];
    logic [47:0] pool [10];
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++)
      for (int w = 0; w < NW; w++) begin
        m_vld[i][w] = 1'b0; m_mac[i][w] = '0; m_port[i][w] = '0;
        m_age[i][w] = 1'b0; m_stat[i][w] = 1'b0; m_intv[i][w] = 1'b0;
      end
    rst_n = 1'b0; frm_valid = 1'b0; frm_sa = '0; frm_da = '0; frm_port = '0;
    cpu_present = 1'b0; flood_en = 8'hF7; age_tick = 1'b0;
    mg_valid = 1'b0; mg_op = '0; mg_mac = '0; mg_port = '0; mg_static = 1'b0; mg_intv = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "reset frm_ready", frm_ready, 1);
    chk("R11", "reset fwd_valid", fwd_valid, 0);
    chk("R11", "reset learn_new", learn_new, 0);
    chk("R11", "reset drop_cnt", drop_cnt, 0);

    a = mk_mac(1); b = mk_mac(2); c = mk_mac(1); d = mk_mac(5); e = mk_mac(6);
    send_frame(a, b, 3'd2, "R3");     // unknown destination floods, A learned
    send_frame(b, a, 3'd5, "R1");     // hit on learned port
    @(negedge clk);
    chk("R2", "learn_new single pulse", learn_new, 0);
    send_frame(a, b, 3'd2, "R2");     // refresh, no notification
    send_frame(a, b, 3'd6, "R6");     // move A to port 6
    send_frame(b, a, 3'd5, "R6");
    send_frame(c, a, 3'd6, "R5");     // destination on ingress port: filtered
    send_mgmt(2'b00, a, 3'd1, 1'b1, 1'b1);
    send_frame(b, a, 3'd5, "R7");     // static, intervene adds CPU bit
    send_frame(a, b, 3'd4, "R6");     // static entry not moved
    send_frame(b, a, 3'd5, "R5");
    mc = b; mc[40] = 1'b1;
    send_frame(c, mc, 3'd3, "R4");    // multicast floods without CPU
    cpu_present = 1'b1;
    send_frame(c, mc, 3'd3, "R4");    // multicast to CPU
    send_frame(mc, a, 3'd3, "R4");    // multicast source not learned
    cpu_present = 1'b0;
    send_frame(d, a, 3'd3, "R8");
    send_frame(e, a, 3'd4, "R8");
    send_tick();
    send_frame(e, a, 3'd4, "R8");     // refresh E only
    send_tick();
    send_frame(c, d, 3'd2, "R8");     // D aged out
    send_frame(c, e, 3'd2, "R8");     // E kept
    send_frame(c, a, 3'd2, "R8");     // static A kept
    send_mgmt(2'b01, b, 3'd0, 1'b0, 1'b0);
    send_frame(c, b, 3'd2, "R7");     // deleted
    send_mgmt(2'b10, a, 3'd3, 1'b0, 1'b0);
    send_frame(c, a, 3'd2, "R7");     // reserved op changes nothing
    for (int i = 0; i < 5; i++) full[i] = mk_mac(7);
    for (int i = 0; i < 5; i++) send_frame(full[i], a, 3'(i + 2), "R9");
    send_mgmt(2'b01, full[1], 3'd0, 1'b0, 1'b0);
    send_frame(full[4], a, 3'd6, "R9");
    send_frame(c, full[4], 3'd2, "R9");
    stall_case(mk_mac(11), a, 3'd4);

    for (int i = 0; i < 10; i++) pool[i] = mk_mac((i < 6) ? 3 : 9);
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      if (n % 150 == 0) cpu_present = ~cpu_present;
      if (r < 70) begin
        logic [47:0] da = pool[$urandom_range(0, 9)];
        if ($urandom_range(0, 9) == 0) da[40] = 1'b1;
        send_frame(pool[$urandom_range(0, 9)], da, 3'($urandom_range(0, 7)), "R1/R3 random");
      end else if (r < 92) begin
        send_mgmt(2'($urandom_range(0, 3)), pool[$urandom_range(0, 9)],
                  3'($urandom_range(0, 7)), ($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)));
      end else begin
        send_tick();
      end
    end
    finish_run();
  end
endmodule